// File: doc/BRIEF.md
# MSI capability register file

This block holds the message-signalled-interrupt capability structure of one function's configuration space. Configuration writes and reads arrive as dword-addressed accesses with four byte enables. The block decodes them against a capability base offset set by a parameter. Two register layouts are available: one with a 32-bit message address and one with a 64-bit message address. The layout decides where the data, mask and pending dwords sit.

A message dispatcher next to the block uses its outputs. These are the enable bit, the multiple-message-enable field, the full message address, the data word, the 32 per-vector mask bits and the 32 pending bits. The dispatcher alone sets and clears pending bits. When a masked vector is unmasked while messages are enabled, the block raises a one-cycle pulse for that vector, so the dispatcher can send any message that was held back.

Top module: `msi_cap_regs`

## Requirements
- R1: After reset, the header dword at the base offset reads as follows. Byte 0 is the capability ID 0x05. Byte 1 is the NEXT_PTR parameter. Bytes 2–3 hold the control word: bit 8 is 1 (per-vector masking), bit 7 is 1 only in the 64-bit layout, bits 3:1 are the capable count, and every other bit is 0. Address, data, mask and pending all read 0.
- R2: The capable count in control bits 3:1 is the smallest n in 0..5 with 2^n ≥ VEC_COUNT. A VEC_COUNT above 32, or below 1, stops elaboration with an error.
- R3: The capability ID byte and the next-pointer byte ignore every write.
- R4: In the control word, only bit 0 (enable, driven on msiEnable) and bits 6:4 (multiple-message enable, driven on multiMsgEn) take write data. Bits 1–3, bit 7 and bits 15:8 keep their values.
- R5: The offsets from the base are fixed by the layout. In the 64-bit layout: address low +4, address high +8, data +0xC, mask +0x10, pending +0x14. In the 32-bit layout: address low +4, data +8, mask +0xC, pending +0x10. The data dword keeps 16 bits, and its upper half reads 0 and ignores writes.
- R6: A write changes only the bytes whose byte enable is set. Bit b of mask byte k masks vector 8k+b.
- R7: A read returns its data on cfgRdData in the cycle after cfgRdEn. Bytes that are not enabled read 0, and so does any dword outside the capability. cfgRdData is 0 in a cycle that follows no read.
- R8: Configuration writes do not change the pending dword. A pendSet bit sets its pending bit, and a pendClr bit clears it. Set wins when both are high. The result shows on pendBits one cycle later.
- R9: While msiEnable is 1, a write that takes a mask bit from 1 to 0 drives unmaskPulse for that vector high for exactly the cycle after the write. Writes that set mask bits, or that happen while msiEnable is 0, produce no pulse.
- R10: msgAddr carries {address high, address low}, with the high half 0 in the 32-bit layout. msgData carries the 16-bit data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgRdEn | input | 1 | Configuration read strobe |
| cfgAddr | input | 8 | Byte address of the accessed dword (bits 1:0 ignored) |
| cfgByteEn | input | 4 | Byte enables of the access |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data, one cycle after cfgRdEn |
| pendSet | input | 32 | Per-vector pending set from the dispatcher |
| pendClr | input | 32 | Per-vector pending clear from the dispatcher |
| msiEnable | output | 1 | Message enable bit |
| multiMsgEn | output | 3 | Multiple-message-enable field |
| msgAddr | output | 64 | Message address |
| msgData | output | 16 | Message data |
| maskBits | output | 32 | Per-vector mask bits |
| pendBits | output | 32 | Per-vector pending bits |
| unmaskPulse | output | 32 | One-cycle per-vector unmask event |

## Verification
The bench writes all ones to the header dword. A design that leaks write data into the ID, the next pointer or a read-only control bit then reads back a wrong header. It checks both layouts side by side: a layout mix-up would put data where the mask belongs, or let address-high bits appear in the 32-bit layout. Mask clears are tried in byte 0 and byte 1, with messages enabled and disabled. A wrong vector index, a pulse longer than one cycle, or a pulse while disabled all show up on unmaskPulse. The bench also writes to pending, drives set and clear together, and reads partial bytes and dwords outside the capability. These tests catch a writable pending dword, clear-over-set priority and unmasked read data.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_HDR, SEL_ALO, SEL_AHI, SEL_DATA, SEL_MASK, SEL_PEND
  } regSel_t;

  typedef struct packed {
    logic       wr;
    logic       rd;
    regSel_t    sel;
    logic [3:0] be;
  } strobes_t;

  localparam logic [7:0] CAP_ID = 8'h05;

  function automatic logic [2:0] capableCount(input int cnt);
    logic [2:0] n;
    logic       found;
    n = 3'd5;
    found = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (!found && ((1 << i) >= cnt)) begin
        n = 3'(i);
        found = 1'b1;
      end
    end
    return n;
  endfunction

  function automatic logic [31:0] mergeBytes(input logic [31:0] oldV,
                                             input logic [31:0] newV,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int k = 0; k < 4; k++)
      r[k*8 +: 8] = be[k] ? newV[k*8 +: 8] : oldV[k*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] beMask(input logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++)
      m[k*8 +: 8] = {8{be[k]}};
    return m;
  endfunction

endpackage

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
  import msi_cap_pkg::*;
#(
  parameter logic [7:0] CAP_OFS = 8'h50,
  parameter bit         IS64    = 1'b1
) (
  input  logic       cfgWrEn,
  input  logic       cfgRdEn,
  input  logic [7:0] cfgAddr,
  input  logic [3:0] cfgByteEn,
  output strobes_t   strb
);
  localparam int CAP_DW = IS64 ? 6 : 5;

  logic [5:0] relDw;
  logic       inCap;
  logic       unusedAddrBits;

  assign unusedAddrBits = ^cfgAddr[1:0];
  assign relDw = cfgAddr[7:2] - CAP_OFS[7:2];
  assign inCap = (cfgAddr[7:2] >= CAP_OFS[7:2]) && (relDw < 6'(CAP_DW));

  always_comb begin
    strb.wr  = cfgWrEn;
    strb.rd  = cfgRdEn;
    strb.be  = cfgByteEn;
    strb.sel = SEL_NONE;
    if (inCap) begin
      unique case (relDw)
        6'd0: strb.sel = SEL_HDR;
        6'd1: strb.sel = SEL_ALO;
        6'd2: strb.sel = IS64 ? SEL_AHI  : SEL_DATA;
        6'd3: strb.sel = IS64 ? SEL_DATA : SEL_MASK;
        6'd4: strb.sel = IS64 ? SEL_MASK : SEL_PEND;
        6'd5: strb.sel = SEL_PEND;
        default: strb.sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/msi_cap_dp.sv
module msi_cap_dp
  import msi_cap_pkg::*;
#(
  parameter bit         IS64     = 1'b1,
  parameter logic [2:0] MMC      = 3'd0,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic        clk,
  input  logic        rst,
  input  strobes_t    strb,
  input  logic [31:0] wd,
  input  logic [31:0] pendSet,
  input  logic [31:0] pendClr,
  output logic [31:0] rdData,
  output logic        msiEnable,
  output logic [2:0]  multiMsgEn,
  output logic [63:0] msgAddr,
  output logic [15:0] msgData,
  output logic [31:0] maskBits,
  output logic [31:0] pendBits,
  output logic [31:0] unmaskPulse
);
  logic        ctlEn;
  logic [2:0]  ctlMme;
  logic [31:0] addrLo, addrHi, mask, pend, pulse, rdReg;
  logic [15:0] data16;
  logic [15:0] ctlWord;
  logic [31:0] rdWord, newMask;
  logic        wrHdr, wrAlo, wrData, wrMask;

  assign wrHdr  = strb.wr && (strb.sel == SEL_HDR);
  assign wrAlo  = strb.wr && (strb.sel == SEL_ALO);
  assign wrData = strb.wr && (strb.sel == SEL_DATA);
  assign wrMask = strb.wr && (strb.sel == SEL_MASK);
  assign newMask = mergeBytes(mask, wd, strb.be);

  assign ctlWord = {7'd0, 1'b1, IS64, ctlMme, MMC, ctlEn};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctlEn  <= 1'b0;
      ctlMme <= 3'd0;
      addrLo <= '0;
      data16 <= '0;
      mask   <= '0;
      pend   <= '0;
      pulse  <= '0;
    end else begin
      if (wrHdr && strb.be[2]) begin
        ctlEn  <= wd[16];
        ctlMme <= wd[22:20];
      end
      if (wrAlo) addrLo <= newAloVal(addrLo);
      if (wrData) begin
        if (strb.be[0]) data16[7:0]  <= wd[7:0];
        if (strb.be[1]) data16[15:8] <= wd[15:8];
      end
      if (wrMask) mask <= newMask;
      pulse <= (wrMask && ctlEn) ? (mask & ~newMask) : '0;
      pend  <= (pend & ~pendClr) | pendSet;
    end
  end

  function automatic logic [31:0] newAloVal(input logic [31:0] oldV);
    return mergeBytes(oldV, wd, strb.be);
  endfunction

  generate
    if (IS64) begin : g_hi
      logic wrAhi;
      assign wrAhi = strb.wr && (strb.sel == SEL_AHI);
      always_ff @(posedge clk) begin
        if (rst)        addrHi <= '0;
        else if (wrAhi) addrHi <= mergeBytes(addrHi, wd, strb.be);
      end
    end else begin : g_nohi
      assign addrHi = '0;
    end
  endgenerate

  always_comb begin
    unique case (strb.sel)
      SEL_HDR:  rdWord = {ctlWord, NEXT_PTR, CAP_ID};
      SEL_ALO:  rdWord = addrLo;
      SEL_AHI:  rdWord = addrHi;
      SEL_DATA: rdWord = {16'd0, data16};
      SEL_MASK: rdWord = mask;
      SEL_PEND: rdWord = pend;
      default:  rdWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdReg <= '0;
    else     rdReg <= strb.rd ? (rdWord & beMask(strb.be)) : '0;
  end

  assign rdData      = rdReg;
  assign msiEnable   = ctlEn;
  assign multiMsgEn  = ctlMme;
  assign msgAddr     = {addrHi, addrLo};
  assign msgData     = data16;
  assign maskBits    = mask;
  assign pendBits    = pend;
  assign unmaskPulse = pulse;
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int         VEC_COUNT = 4,
  parameter bit         IS64      = 1'b1,
  parameter logic [7:0] CAP_OFS   = 8'h50,
  parameter logic [7:0] NEXT_PTR  = 8'h70
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfgWrEn,
  input  logic        cfgRdEn,
  input  logic [7:0]  cfgAddr,
  input  logic [3:0]  cfgByteEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  input  logic [31:0] pendSet,
  input  logic [31:0] pendClr,
  output logic        msiEnable,
  output logic [2:0]  multiMsgEn,
  output logic [63:0] msgAddr,
  output logic [15:0] msgData,
  output logic [31:0] maskBits,
  output logic [31:0] pendBits,
  output logic [31:0] unmaskPulse
);
  localparam logic [2:0] MMC = capableCount(VEC_COUNT);

  generate
    if (VEC_COUNT > 32 || VEC_COUNT < 1) begin : g_badcount
      $error("msi_cap_regs: VEC_COUNT must be in 1..32");
    end
  endgenerate

  strobes_t strb;

  msi_cap_ctrl #(.CAP_OFS(CAP_OFS), .IS64(IS64)) u_ctrl (
    .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .strb(strb)
  );

  msi_cap_dp #(.IS64(IS64), .MMC(MMC), .NEXT_PTR(NEXT_PTR)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wd(cfgWrData),
    .pendSet(pendSet), .pendClr(pendClr), .rdData(cfgRdData),
    .msiEnable(msiEnable), .multiMsgEn(multiMsgEn), .msgAddr(msgAddr),
    .msgData(msgData), .maskBits(maskBits), .pendBits(pendBits),
    .unmaskPulse(unmaskPulse)
  );
endmodule

// File: rtl/msi_cap_chk.sv
module msi_cap_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfgWrEn,
  input logic        cfgRdEn,
  input logic [31:0] cfgRdData,
  input logic [31:0] pendSet,
  input logic [31:0] pendClr,
  input logic        msiEnable,
  input logic [2:0]  multiMsgEn,
  input logic [31:0] maskBits,
  input logic [31:0] pendBits,
  input logic [31:0] unmaskPulse
);
  AST_PULSE_WAS_MASKED: assert property (@(posedge clk) disable iff (rst)
    (unmaskPulse != 0) |-> (((unmaskPulse & ~$past(maskBits)) == 0) && ((unmaskPulse & maskBits) == 0))); // R9

  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (unmaskPulse != 0) |-> $past(msiEnable)); // R9

  AST_PULSE_NEEDS_WR: assert property (@(posedge clk) disable iff (rst)
    (unmaskPulse != 0) |-> $past(cfgWrEn)); // R9

  AST_PEND_RISE_SRC: assert property (@(posedge clk) disable iff (rst)
    ((pendBits & ~$past(pendBits) & ~$past(pendSet)) == 0)); // R8

  AST_PEND_FALL_SRC: assert property (@(posedge clk) disable iff (rst)
    (($past(pendBits) & ~pendBits & ~$past(pendClr)) == 0)); // R8

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(cfgWrEn) |-> ($stable(msiEnable) && $stable(multiMsgEn))); // R4

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(cfgRdEn) |-> (cfgRdData == 0)); // R7
endmodule

bind msi_cap_regs msi_cap_chk u_chk (
  .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
  .cfgRdData(cfgRdData), .pendSet(pendSet), .pendClr(pendClr),
  .msiEnable(msiEnable), .multiMsgEn(multiMsgEn), .maskBits(maskBits),
  .pendBits(pendBits), .unmaskPulse(unmaskPulse)
);

// File: tb/sim_msi_cap_regs.sv
`timescale 1ns/1ps
module sim_msi_cap_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0, rdEn = 1'b0, sel = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdat = '0, pSet = '0, pClr = '0;
  logic [31:0] rd0, rd1, mask0, mask1, pend0, pend1, pul0, pul1;
  logic        en0, en1;
  logic [2:0]  mme0, mme1;
  logic [63:0] ad0, ad1;
  logic [15:0] dt0, dt1;
  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  msi_cap_regs u0 (
    .clk(clk), .rst(rst), .cfgWrEn(wrEn && !sel), .cfgRdEn(rdEn && !sel),
    .cfgAddr(addr), .cfgByteEn(be), .cfgWrData(wdat), .cfgRdData(rd0),
    .pendSet(sel ? 32'd0 : pSet), .pendClr(sel ? 32'd0 : pClr),
    .msiEnable(en0), .multiMsgEn(mme0), .msgAddr(ad0), .msgData(dt0),
    .maskBits(mask0), .pendBits(pend0), .unmaskPulse(pul0));

  msi_cap_regs #(.VEC_COUNT(32), .IS64(1'b0)) u1 (
    .clk(clk), .rst(rst), .cfgWrEn(wrEn && sel), .cfgRdEn(rdEn && sel),
    .cfgAddr(addr), .cfgByteEn(be), .cfgWrData(wdat), .cfgRdData(rd1),
    .pendSet(sel ? pSet : 32'd0), .pendClr(sel ? pClr : 32'd0),
    .msiEnable(en1), .multiMsgEn(mme1), .msgAddr(ad1), .msgData(dt1),
    .maskBits(mask1), .pendBits(pend1), .unmaskPulse(pul1));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input bit s, input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    sel = s; addr = a; be = b; wdat = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic cfgRead(input bit s, input logic [7:0] a, input logic [3:0] b, output logic [31:0] d);
    @(negedge clk);
    sel = s; addr = a; be = b; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = s ? rd1 : rd0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    cfgRead(0, 8'h50, 4'hF, d); check("R1 hdr64", d, 32'h01847005);
    cfgRead(1, 8'h50, 4'hF, d); check("R2 hdr32 mmc5", d, 32'h010A7005);
    check("R1 mask/pend zero", {mask0, pend0}, 64'd0);
    check("R1 addr zero", ad0, 64'd0);
    check("R7 idle zero", rd0, 32'd0);
  endtask

  task automatic testHeader();
    logic [31:0] d;
    cfgWrite(0, 8'h50, 4'hF, 32'hFFFF_FFFF);
    cfgRead(0, 8'h50, 4'hF, d); check("R3 R4 hdr after ones", d, 32'h01F57005);
    check("R4 enable mme", {en0, mme0}, 4'hF);
    cfgRead(0, 8'h50, 4'h1, d); check("R7 byte read", d, 32'h05);
    cfgWrite(0, 8'h50, 4'h4, 32'h0);
    check("R4 enable cleared", {en0, mme0}, 4'h0);
    cfgWrite(0, 8'h50, 4'h4, 32'h0001_0000);
    check("R4 enable set", en0, 1'b1);
  endtask

  task automatic testAddrData();
    logic [31:0] d;
    cfgWrite(0, 8'h54, 4'hF, 32'h1234_5678);
    cfgWrite(0, 8'h58, 4'hF, 32'h9ABC_DEF0);
    cfgWrite(0, 8'h5C, 4'hF, 32'hFFFF_BEEF);
    check("R10 msgAddr", ad0, 64'h9ABCDEF0_12345678);
    check("R10 msgData", dt0, 16'hBEEF);
    cfgRead(0, 8'h5C, 4'hF, d); check("R5 data upper zero", d, 32'h0000BEEF);
    cfgWrite(0, 8'h54, 4'h2, 32'h0000_AA00);
    check("R6 partial byte", ad0[31:0], 32'h1234AA78);
    cfgRead(0, 8'h68, 4'hF, d); check("R7 past end", d, 32'd0);
    cfgRead(0, 8'h4C, 4'hF, d); check("R7 before base", d, 32'd0);
  endtask

  task automatic testUnmask();
    cfgWrite(0, 8'h60, 4'h1, 32'h0000_00FF);
    check("R9 set no pulse", pul0, 32'd0);
    cfgWrite(0, 8'h60, 4'h1, 32'h0000_00F0);
    check("R9 pulse byte0", pul0, 32'h0000000F);
    check("R6 mask value", mask0, 32'h000000F0);
    @(negedge clk); check("R9 pulse one cycle", pul0, 32'd0);
    cfgWrite(0, 8'h60, 4'h2, 32'h0000_8100);
    check("R6 mask byte1", mask0, 32'h000081F0);
    cfgWrite(0, 8'h60, 4'h2, 32'h0);
    check("R9 pulse vec 8 15", pul0, 32'h00008100);
    cfgWrite(0, 8'h50, 4'h4, 32'h0);
    cfgWrite(0, 8'h60, 4'h1, 32'h0);
    check("R9 disabled no pulse", pul0, 32'd0);
    check("R6 mask cleared", mask0, 32'd0);
  endtask

  task automatic testPending();
    logic [31:0] d;
    cfgWrite(0, 8'h64, 4'hF, 32'hFFFF_FFFF);
    cfgRead(0, 8'h64, 4'hF, d); check("R8 cfg write ignored", d, 32'd0);
    @(negedge clk); sel = 0; pSet = 32'h5;
    @(negedge clk); pSet = 32'h1; pClr = 32'h1;
    check("R8 set", pend0, 32'h5);
    @(negedge clk); pSet = 0; pClr = 32'h4;
    check("R8 set wins", pend0, 32'h5);
    @(negedge clk); pClr = 0;
    check("R8 clear", pend0, 32'h1);
    cfgRead(0, 8'h64, 4'hF, d); check("R8 read pending", d, 32'h1);
  endtask

  task automatic testLayout32();
    logic [31:0] d;
    cfgWrite(1, 8'h54, 4'hF, 32'hCAFE_0004);
    cfgWrite(1, 8'h58, 4'hF, 32'h1111_CAFE);
    check("R5 32 data at +8", dt1, 16'hCAFE);
    check("R10 32 addr hi zero", ad1, 64'h00000000_CAFE0004);
    cfgWrite(1, 8'h5C, 4'hF, 32'h0000_00F0);
    check("R5 32 mask at +C", mask1, 32'h000000F0);
    cfgRead(1, 8'h64, 4'hF, d); check("R5 32 past end", d, 32'd0);
    @(negedge clk); sel = 1; pSet = 32'h8000_0000;
    @(negedge clk); pSet = 0;
    cfgRead(1, 8'h60, 4'hF, d); check("R5 32 pend at +10", d, 32'h80000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testHeader();
    testAddrData();
    testUnmask();
    testPending();
    testLayout32();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChk++; nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule